// File: doc/BRIEF.md
# Configurable Bidirectional Pin Cell

This block is a single programmable pad cell placed between one bit of internal logic and one device pin. The pad is modelled with three separate signals (value seen at the pad, value driven onto the pad, and a drive enable) rather than a real tri-state net, so the cell can sit inside ordinary synchronous logic and be checked at its ports.

A static configuration chooses three things. The first is how the pad value is captured for the fabric: passed straight through, sampled by a flop, or held by a level-sensitive latch, all timed by a dedicated I/O clock. The second is the pin direction: input only, output only, or bidirectional with a local drive enable from the core. The third is the drive style: totem-pole, which drives both levels, or open-drain, which only pulls low. A shared global output enable can switch off the driver whatever the local setting is. With an all-zero configuration the cell is a plain combinational input with totem-pole drive style.

Top module: `bidir_pin_cell`

## Requirements
- R1: With capture mode 2'b00, core_din equals pad_i in the same cycle, with no clock involved, whenever the direction is not output-only.
- R2: With capture mode 2'b01, core_din shows the pad_i value sampled at the most recent rising edge of io_clk and does not change between edges.
- R3: With capture mode 2'b10, core_din follows pad_i while io_clk is high and holds the value it had when io_clk fell for as long as io_clk stays low.
- R4: rst_n is active low. While it is low, the capture latch output is 0 immediately, and the capture flop is 0 after the next rising edge of io_clk.
- R5: Direction code 2'b00 and 2'b11 are input only, so pad_oe is 0. Code 2'b01 is output only, so the local enable is 1. Code 2'b10 is bidirectional, so the local enable is core_oe.
- R6: When glob_oe is 0, pad_oe is 0 under every configuration and data value.
- R7: With cfg_open_drain at 0 (totem-pole), pad_o equals core_dout and pad_oe equals the local enable ANDed with glob_oe.
- R8: With cfg_open_drain at 1, pad_o is 0 and pad_oe equals the local enable ANDed with glob_oe and with the inverse of core_dout. The pad is released whenever the data is 1.
- R9: With direction output only (2'b01), core_din equals core_dout in the same cycle, whatever the capture mode and pad_i are.
- R10: With the all-zero configuration, the cell is a combinational input with pad_oe at 0 and totem-pole drive style.
- R11: Capture mode code 2'b11 behaves the same as 2'b00 (combinational).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| io_clk | input | 1 | Dedicated I/O clock for the capture flop and latch |
| rst_n | input | 1 | Active-low global reset of the capture storage |
| cfg_cap_mode | input | 2 | Static capture mode: 00 comb, 01 flop, 10 latch, 11 comb |
| cfg_dir | input | 2 | Static direction: 00 in, 01 out, 10 bidir, 11 in |
| cfg_open_drain | input | 1 | Static drive style: 1 open-drain, 0 totem-pole |
| glob_oe | input | 1 | Shared global output enable, active high |
| core_dout | input | 1 | Data from the fabric to drive onto the pad |
| core_oe | input | 1 | Local drive enable from the fabric (bidir mode) |
| core_din | output | 1 | Captured or read-back value presented to the fabric |
| pad_i | input | 1 | Value currently present at the pin |
| pad_o | output | 1 | Value driven onto the pin when enabled |
| pad_oe | output | 1 | Pin driver enable |

## Verification
The hardest behaviour to reach from the ports is the hold phase of the input latch. It only shows when the pad changes while io_clk is low, and it must end exactly when the clock rises again. The bench therefore moves pad_i in the middle of the low phase and checks core_din before and after the next rising edge. It also asserts reset in the middle of a high phase to show that the latch clears at once and does not wait for an edge. The drive logic is swept over every combination of direction, drive style, global enable, local enable, data and pad value.

// File: rtl/pin_cell_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the configurable pin cell.
// Assumes the configuration inputs are static while the cell is in use.
package pin_cell_pkg;

    localparam int CAP_W = 2;
    localparam int DIR_W = 2;

    typedef enum logic [CAP_W-1:0] {
        CAP_COMB     = 2'b00,
        CAP_FLOP     = 2'b01,
        CAP_LATCH    = 2'b10,
        CAP_COMB_ALT = 2'b11
    } cap_mode_e;

    typedef enum logic [DIR_W-1:0] {
        DIR_IN     = 2'b00,
        DIR_OUT    = 2'b01,
        DIR_BIDIR  = 2'b10,
        DIR_IN_ALT = 2'b11
    } dir_mode_e;

endpackage

// File: rtl/pin_in_capture.sv
`timescale 1ns/1ps
// Module: input capture path of the pin cell.
// Holds a flop clocked on the rising edge of io_clk and a latch that is
// transparent while io_clk is high, and selects one of them or the raw pad.
// Assumes: rst_n is active low. It is synchronous for the flop and
// level-sensitive for the latch.
module pin_in_capture
    import pin_cell_pkg::*;
(
    input  logic             io_clk,
    input  logic             rst_n,
    input  logic [CAP_W-1:0] cap_sel,
    input  logic             pad_val,
    output logic             cap_val
);

    logic flop_q;
    logic latch_q;
    cap_mode_e mode;

    assign mode = cap_mode_e'(cap_sel);

    // Sample the pad on each rising edge of the I/O clock.
    always_ff @(posedge io_clk) begin
        if (!rst_n) begin
            flop_q <= 1'b0;
        end else begin
            flop_q <= pad_val;
        end
    end

    // Pass the pad while the I/O clock is high; hold it while the clock is low.
    always_latch begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else if (io_clk) begin
            latch_q <= pad_val;
        end
    end

    // Choose the captured value for the fabric.
    always_comb begin
        case (mode)
            CAP_FLOP:  cap_val = flop_q;
            CAP_LATCH: cap_val = latch_q;
            default:   cap_val = pad_val;
        endcase
    end

endmodule

// File: rtl/pin_drive_ctl.sv
`timescale 1ns/1ps
// Module: output driver control of the pin cell.
// Resolves the local enable from the direction code, gates it with the
// global enable, and applies totem-pole or open-drain drive style.
// Assumes: the direction and style codes are static.
module pin_drive_ctl
    import pin_cell_pkg::*;
(
    input  logic [DIR_W-1:0] dir_sel,
    input  logic             open_drain,
    input  logic             glob_oe,
    input  logic             dout,
    input  logic             loc_oe,
    output logic             pad_o,
    output logic             pad_oe
);

    dir_mode_e dir;
    logic      local_en;
    logic      gated_en;

    assign dir = dir_mode_e'(dir_sel);

    // Pick the local drive enable from the direction code.
    always_comb begin
        case (dir)
            DIR_OUT:   local_en = 1'b1;
            DIR_BIDIR: local_en = loc_oe;
            default:   local_en = 1'b0;
        endcase
    end

    // Apply the shared global enable on top of the local one.
    assign gated_en = local_en & glob_oe;

    // Apply the drive style: open-drain only pulls low and releases on a 1.
    always_comb begin
        if (open_drain) begin
            pad_o  = 1'b0;
            pad_oe = gated_en & ~dout;
        end else begin
            pad_o  = dout;
            pad_oe = gated_en;
        end
    end

endmodule

// File: rtl/bidir_pin_cell.sv
`timescale 1ns/1ps
// Module: configurable bidirectional pin cell (top).
// Joins the capture path and the driver control. In output-only mode the
// fabric reads back the value it drives instead of the captured pad.
// Assumes: configuration inputs are static; the pad is modelled as separate
// in / out / enable signals.
module bidir_pin_cell
    import pin_cell_pkg::*;
(
    input  logic             io_clk,
    input  logic             rst_n,
    input  logic [CAP_W-1:0] cfg_cap_mode,
    input  logic [DIR_W-1:0] cfg_dir,
    input  logic             cfg_open_drain,
    input  logic             glob_oe,
    input  logic             core_dout,
    input  logic             core_oe,
    output logic             core_din,
    input  logic             pad_i,
    output logic             pad_o,
    output logic             pad_oe
);

    logic cap_val;

    pin_in_capture u_capture (
        .io_clk  (io_clk),
        .rst_n   (rst_n),
        .cap_sel (cfg_cap_mode),
        .pad_val (pad_i),
        .cap_val (cap_val)
    );

    pin_drive_ctl u_drive (
        .dir_sel    (cfg_dir),
        .open_drain (cfg_open_drain),
        .glob_oe    (glob_oe),
        .dout       (core_dout),
        .loc_oe     (core_oe),
        .pad_o      (pad_o),
        .pad_oe     (pad_oe)
    );

    // Return the driven value in output-only mode, else the captured pad.
    always_comb begin
        if (dir_mode_e'(cfg_dir) == DIR_OUT) begin
            core_din = core_dout;
        end else begin
            core_din = cap_val;
        end
    end

endmodule

// File: rtl/bidir_pin_cell_chk.sv
`timescale 1ns/1ps
// Module: property checker for the pin cell, attached by bind.
// Assumes: sampling on the rising edge of io_clk is enough for the
// combinational relations it checks.
module bidir_pin_cell_chk
    import pin_cell_pkg::*;
(
    input logic             io_clk,
    input logic             rst_n,
    input logic [CAP_W-1:0] cfg_cap_mode,
    input logic [DIR_W-1:0] cfg_dir,
    input logic             cfg_open_drain,
    input logic             glob_oe,
    input logic             core_dout,
    input logic             core_oe,
    input logic             core_din,
    input logic             pad_i,
    input logic             pad_o,
    input logic             pad_oe
);

    logic unused_oe;
    assign unused_oe = core_oe;

    a_r6_global_off: assert property (@(posedge io_clk) disable iff (!rst_n)
        !glob_oe |-> !pad_oe);

    a_r8_od_never_high: assert property (@(posedge io_clk) disable iff (!rst_n)
        cfg_open_drain |-> (pad_o == 1'b0) && !(core_dout && pad_oe));

    a_r7_totem_follows: assert property (@(posedge io_clk) disable iff (!rst_n)
        (!cfg_open_drain && pad_oe) |-> (pad_o == core_dout));

    a_r5_input_quiet: assert property (@(posedge io_clk) disable iff (!rst_n)
        (cfg_dir == 2'b00 || cfg_dir == 2'b11) |-> !pad_oe);

    a_r9_readback: assert property (@(posedge io_clk) disable iff (!rst_n)
        (cfg_dir == 2'b01) |-> (core_din == core_dout));

    a_r2_flop_capture: assert property (@(posedge io_clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_cap_mode == 2'b01 && cfg_dir != 2'b01 &&
         $stable(cfg_cap_mode) && $stable(cfg_dir)) |-> (core_din == $past(pad_i)));

endmodule

bind bidir_pin_cell bidir_pin_cell_chk i_chk (
    .io_clk         (io_clk),
    .rst_n          (rst_n),
    .cfg_cap_mode   (cfg_cap_mode),
    .cfg_dir        (cfg_dir),
    .cfg_open_drain (cfg_open_drain),
    .glob_oe        (glob_oe),
    .core_dout      (core_dout),
    .core_oe        (core_oe),
    .core_din       (core_din),
    .pad_i          (pad_i),
    .pad_o          (pad_o),
    .pad_oe         (pad_oe)
);

// File: tb/test_bidir_pin_cell.sv
`timescale 1ns/1ps
// Bench: sweeps the pin cell configurations and checks against values
// computed from the requirements.
module test_bidir_pin_cell;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cap;
    logic [1:0] dir;
    logic       od, goe, dout, loe, pad;
    logic       din, po, poe;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    bidir_pin_cell i_bidir_pin_cell (
        .io_clk(clk), .rst_n(rst_n), .cfg_cap_mode(cap), .cfg_dir(dir),
        .cfg_open_drain(od), .glob_oe(goe), .core_dout(dout), .core_oe(loe),
        .core_din(din), .pad_i(pad), .pad_o(po), .pad_oe(poe)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic at_high();
        @(posedge clk); #0.5;
    endtask

    task automatic at_low();
        @(negedge clk); #0.5;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic q_exp;
        logic [15:0] pat;
        pat = 16'b1011_0100_1101_0011;
        // R10: erased configuration during reset
        rst_n = 1'b0; cap = 2'b00; dir = 2'b00; od = 1'b0; goe = 1'b1;
        dout = 1'b1; loe = 1'b1; pad = 1'b1;
        #1;
        chk("R10 pad_oe erased", poe, 1'b0);
        chk("R10 core_din erased", din, 1'b1);
        chk("R10 totem style pad_o", po, dout);
        pad = 1'b0; #0.2;
        chk("R10 core_din erased low", din, 1'b0);
        // R4: flop and latch cleared under reset with pad high
        cap = 2'b01; pad = 1'b1;
        repeat (2) @(posedge clk);
        at_high();
        chk("R4 flop reset", din, 1'b0);
        cap = 2'b10;
        at_high();
        chk("R4 latch reset clock high", din, 1'b0);
        at_low();
        rst_n = 1'b1;

        // R1 R5 R6 R7 R8 R9 R11: exhaustive drive/readback sweep
        for (int c = 0; c < 2; c++)
        for (int d = 0; d < 4; d++)
        for (int o = 0; o < 2; o++)
        for (int g = 0; g < 2; g++)
        for (int l = 0; l < 2; l++)
        for (int v = 0; v < 2; v++)
        for (int p = 0; p < 2; p++) begin
            logic le, en, eoe, epo, edin;
            at_high();
            cap = (c == 1) ? 2'b11 : 2'b00;
            dir = 2'(d); od = 1'(o); goe = 1'(g); loe = 1'(l);
            dout = 1'(v); pad = 1'(p);
            #0.3;
            le   = (d == 1) ? 1'b1 : ((d == 2) ? 1'(l) : 1'b0);
            en   = le & 1'(g);
            eoe  = (o == 1) ? (en & ~1'(v)) : en;
            epo  = (o == 1) ? 1'b0 : 1'(v);
            edin = (d == 1) ? 1'(v) : 1'(p);
            if (g == 0)                chk("R6 pad_oe global off", poe, eoe);
            else if (d == 0 || d == 3) chk("R5 pad_oe input only", poe, eoe);
            else if (o == 1)           chk("R8 pad_oe open drain", poe, eoe);
            else                       chk("R7 pad_oe totem", poe, eoe);
            if (o == 1) chk("R8 pad_o open drain", po, epo);
            else        chk("R7 pad_o totem", po, epo);
            if (d == 1)      chk("R9 core_din readback", din, edin);
            else if (c == 1) chk("R11 core_din alt comb", din, edin);
            else             chk("R1 core_din comb", din, edin);
        end

        // R2: flop capture, input-only and bidir directions
        od = 1'b0; goe = 1'b1; loe = 1'b0;
        at_low();
        cap = 2'b01; dir = 2'b00; pad = 1'b0;
        at_high();
        q_exp = 1'b0;
        for (int k = 0; k < 2; k++) begin
            dir = (k == 0) ? 2'b00 : 2'b10;
            for (int i = 0; i < 16; i++) begin
                at_low();
                pad = pat[i];
                #0.3;
                chk("R2 flop holds before edge", din, q_exp);
                at_high();
                q_exp = pat[i];
                chk("R2 flop captured at edge", din, q_exp);
            end
        end

        // R3: latch transparent while high, holds while low
        at_low();
        cap = 2'b10; dir = 2'b00;
        for (int i = 0; i < 8; i++) begin
            at_high();
            pad = pat[i];
            #0.3;
            chk("R3 latch transparent", din, pat[i]);
            at_low();
            pad = ~pat[i];
            #0.3;
            chk("R3 latch holds low phase", din, pat[i]);
            at_high();
            chk("R3 latch reopens", din, ~pat[i]);
        end

        // R4: latch cleared at once by reset in the middle of a high phase
        at_high();
        pad = 1'b1; #0.2;
        chk("R4 latch before reset", din, 1'b1);
        rst_n = 1'b0; #0.2;
        chk("R4 latch cleared immediately", din, 1'b0);
        at_low();
        chk("R4 latch stays clear", din, 1'b0);
        // R4: flop cleared by the next rising edge
        cap = 2'b01;
        at_high();
        chk("R4 flop cleared at edge", din, 1'b0);
        at_low();
        rst_n = 1'b1;
        at_high();
        chk("R2 flop after release", din, 1'b1);

        // R9: readback with flop and latch capture modes
        for (int c = 1; c < 3; c++) begin
            at_low();
            cap = 2'(c); dir = 2'b01; od = 1'b0;
            dout = 1'b1; pad = 1'b0; #0.3;
            chk("R9 readback low phase", din, 1'b1);
            at_high();
            chk("R9 readback after edge", din, 1'b1);
            dout = 1'b0; pad = 1'b1; #0.3;
            chk("R9 readback follows data", din, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule